// File: doc/BRIEF.md
# Ethernet PHY Reset, Power-Down and Isolation Controller

This block supervises the digital core of an Ethernet PHY. It merges an external reset pin and a self-clearing software reset bit into one internal reset. A low pulse on the pin takes effect only if it lasts longer than a parameterised number of clock cycles; shorter pulses are treated as noise. While any reset is in progress, two strap inputs are captured. One sets the default isolation state. The other decides whether the free-running 25 MHz clock output is enabled.

Power-down can be requested by a pin or by a control bit. Either request removes the analog enable and holds the rest of the core in reset. The management register port keeps working throughout power-down. Isolation can likewise come from a pin or a control bit. It drops the output enable of the MII output group. In repeater mode, the carrier-sense output keeps its own enable. All asynchronous pins pass through a multi-stage synchronizer, and every control output is registered.

Top module: `phy_mode_ctrl`

## Requirements
- R1: An internal hardware reset starts only after the synchronised reset pin has been sampled low on more than `RST_MIN_CYC` consecutive clock edges. A low pulse of `RST_MIN_CYC` cycles or fewer changes no register.
- R2: While any reset is active, `core_rst` is high and the power-down control bit (bit 11 of the control register at address `CTRL_ADDR`) is forced to 0.
- R3: Writing a word with bit 15 set to address `CTRL_ADDR` starts a software reset of `SW_RST_CYC` cycles. This reset has the same effect as the hardware reset. Bit 15 reads 1 while any reset is active and 0 once it has ended.
- R4: While a reset is active, the isolate strap is loaded into bit 10 of the control register. In the same interval, the clock strap is loaded into `clk25_en`.
- R5: When the power-down pin is high or control bit 11 is 1, `analog_en` is 0 and `core_rst` is 1. Otherwise, outside reset, `analog_en` is 1 and `core_rst` is 0.
- R6: Reads and writes of the control register work during power-down. Read data appears on `mgmt_rdata` one clock after the address is presented. The read word carries bit 15 (reset), bit 11 (power-down) and bit 10 (isolate), with all other bits 0.
- R7: When the isolate pin is high or control bit 10 is 1, `mii_oe` is 0. Otherwise `mii_oe` is 1.
- R8: When `rpt_mode` is high, `crs_oe` is 1 whatever the isolation state. Otherwise `crs_oe` equals `mii_oe`.
- R9: A write to any address other than `CTRL_ADDR` changes no control bit and starts no reset. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Raw active-low reset pin |
| pd_pin | input | 1 | Raw power-down request pin |
| iso_pin | input | 1 | Raw isolate request pin |
| rpt_mode | input | 1 | Repeater-mode select (carrier-sense exempt from isolation) |
| iso_strap | input | 1 | Isolate-default strap, sampled during reset |
| clk_strap | input | 1 | 25 MHz clock-output enable strap, sampled during reset |
| mgmt_addr | input | ADDR_W | Management register address |
| mgmt_wr | input | 1 | Management write strobe |
| mgmt_wdata | input | DATA_W | Management write data |
| mgmt_rdata | output | DATA_W | Registered management read data |
| clk25_en | output | 1 | Enable for the free-running 25 MHz clock output |
| analog_en | output | 1 | Enable for the analog modules |
| core_rst | output | 1 | Reset to the rest of the digital core |
| mii_oe | output | 1 | Output enable of the MII output group |
| crs_oe | output | 1 | Output enable of the carrier-sense output |

## Verification
A wrong pulse-length counter shows up at the ports in two ways. Either a short glitch clears the power-down bit that was written earlier, or a long pulse fails to clear it; either is visible on a read a few cycles after the pulse ends. A stuck software-reset timer leaves bit 15 at 1 and `core_rst` high well past `SW_RST_CYC` cycles. A wrong isolate, power-down or repeater combination appears on `mii_oe`, `crs_oe`, `analog_en` or `core_rst` three clock edges after the pin changes, or one edge after the register write. A strap captured at the wrong time shows up in `clk25_en` and in bit 10 of the first read after reset.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;
   localparam int CTRL_RST_BIT = 15;
   localparam int CTRL_PD_BIT  = 11;
   localparam int CTRL_ISO_BIT = 10;
   localparam int CTRL_MIN_W   = 16;

   typedef struct packed {
      logic rst_n;
      logic pd;
      logic iso;
      logic rpt;
      logic iso_strap;
      logic clk_strap;
   } pin_bus_t;

   localparam int PIN_BUS_W = $bits(pin_bus_t);
endpackage

// File: rtl/phy_sync_bus.sv
module phy_sync_bus #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("phy_sync_bus: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) stg[0] <= d;

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) stg[i] <= stg[i-1];
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/phy_rst_qual.sv
module phy_rst_qual #(
   parameter int RST_MIN_CYC = 3750,
   parameter int SW_RST_CYC  = 16
) (
   input  logic clk,
   input  logic rst_s,
   input  logic sw_req,
   output logic rst_active
);
   localparam int LOW_W = $clog2(RST_MIN_CYC + 1);
   localparam int SW_W  = $clog2(SW_RST_CYC + 1);
   localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(RST_MIN_CYC);
   localparam logic [SW_W-1:0]  SW_LAST = SW_W'(SW_RST_CYC - 1);

   if (RST_MIN_CYC < 1) begin : g_bad_min
      $error("phy_rst_qual: RST_MIN_CYC must be at least 1");
   end
   if (SW_RST_CYC < 1) begin : g_bad_sw
      $error("phy_rst_qual: SW_RST_CYC must be at least 1");
   end

   logic [LOW_W-1:0] low_cnt;
   logic             hw_act;
   logic [SW_W-1:0]  sw_cnt;
   logic             sw_act;

   // Pin low-time qualifier: reset only after more than LOW_LIM low samples.
   always_ff @(posedge clk) begin
      if (rst_s) begin
         low_cnt <= '0;
         hw_act  <= 1'b0;
      end else if (low_cnt != LOW_LIM) begin
         low_cnt <= low_cnt + 1'b1;
      end else begin
         hw_act  <= 1'b1;
      end
   end

   // Software reset timer, overridden by a qualified pin reset.
   always_ff @(posedge clk) begin
      if (hw_act) begin
         sw_act <= 1'b0;
         sw_cnt <= '0;
      end else if (sw_act) begin
         if (sw_cnt == SW_LAST) begin
            sw_act <= 1'b0;
            sw_cnt <= '0;
         end else begin
            sw_cnt <= sw_cnt + 1'b1;
         end
      end else if (sw_req) begin
         sw_act <= 1'b1;
         sw_cnt <= '0;
      end
   end

   assign rst_active = hw_act | sw_act;
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
   import phy_mode_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 16,
   parameter int CTRL_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_active,
   input  logic              iso_strap_s,
   input  logic              clk_strap_s,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pd_bit,
   output logic              iso_bit,
   output logic              clk25_en,
   output logic              sw_req
);
   localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

   if (DATA_W < CTRL_MIN_W) begin : g_bad_data
      $error("phy_ctrl_reg: DATA_W must hold the control bits");
   end
   if (CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("phy_ctrl_reg: CTRL_ADDR outside address space");
   end

   logic hit;
   logic [DATA_W-1:0] rd_nxt;

   assign hit    = (addr == SEL);
   assign sw_req = wr & hit & wdata[CTRL_RST_BIT] & ~rst_active;

   always_ff @(posedge clk) begin
      if (rst_active) begin
         pd_bit   <= 1'b0;
         iso_bit  <= iso_strap_s;
         clk25_en <= clk_strap_s;
      end else if (wr && hit) begin
         pd_bit   <= wdata[CTRL_PD_BIT];
         iso_bit  <= wdata[CTRL_ISO_BIT];
      end
   end

   always_comb begin
      rd_nxt = '0;
      if (hit) begin
         rd_nxt[CTRL_RST_BIT] = rst_active;
         rd_nxt[CTRL_PD_BIT]  = pd_bit;
         rd_nxt[CTRL_ISO_BIT] = iso_bit;
      end
   end

   always_ff @(posedge clk) rdata <= rd_nxt;
endmodule

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
   import phy_mode_pkg::*;
#(
   parameter int RST_MIN_CYC    = 3750,
   parameter int SW_RST_CYC     = 16,
   parameter int SYNC_STAGES    = 2,
   parameter int ADDR_W         = 5,
   parameter int DATA_W         = 16,
   parameter int CTRL_ADDR      = 0,
   parameter bit CRS_EXEMPT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_pin_n,
   input  logic              pd_pin,
   input  logic              iso_pin,
   input  logic              rpt_mode,
   input  logic              iso_strap,
   input  logic              clk_strap,
   input  logic [ADDR_W-1:0] mgmt_addr,
   input  logic              mgmt_wr,
   input  logic [DATA_W-1:0] mgmt_wdata,
   output logic [DATA_W-1:0] mgmt_rdata,
   output logic              clk25_en,
   output logic              analog_en,
   output logic              core_rst,
   output logic              mii_oe,
   output logic              crs_oe
);
   pin_bus_t pins_raw, pins_s;
   logic     rst_active, sw_req, pd_bit, iso_bit;
   logic     pd_any, iso_any, crs_oe_nxt;

   assign pins_raw = '{rst_n: rst_pin_n, pd: pd_pin, iso: iso_pin,
                       rpt: rpt_mode, iso_strap: iso_strap, clk_strap: clk_strap};

   phy_sync_bus #(.W(PIN_BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (pins_raw),
      .q   (pins_s)
   );

   phy_rst_qual #(.RST_MIN_CYC(RST_MIN_CYC), .SW_RST_CYC(SW_RST_CYC)) u_qual (
      .clk        (clk),
      .rst_s      (pins_s.rst_n),
      .sw_req     (sw_req),
      .rst_active (rst_active)
   );

   phy_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
      .clk         (clk),
      .rst_active  (rst_active),
      .iso_strap_s (pins_s.iso_strap),
      .clk_strap_s (pins_s.clk_strap),
      .wr          (mgmt_wr),
      .addr        (mgmt_addr),
      .wdata       (mgmt_wdata),
      .rdata       (mgmt_rdata),
      .pd_bit      (pd_bit),
      .iso_bit     (iso_bit),
      .clk25_en    (clk25_en),
      .sw_req      (sw_req)
   );

   assign pd_any  = pins_s.pd  | pd_bit;
   assign iso_any = pins_s.iso | iso_bit;

   if (CRS_EXEMPT_EN) begin : g_crs_exempt
      assign crs_oe_nxt = ~iso_any | pins_s.rpt;
   end else begin : g_crs_follow
      assign crs_oe_nxt = ~iso_any;
   end

   always_ff @(posedge clk) begin
      analog_en <= ~pd_any;
      core_rst  <= rst_active | pd_any;
      mii_oe    <= ~iso_any;
      crs_oe    <= crs_oe_nxt;
   end
endmodule

// File: rtl/phy_mode_ctrl_chk.sv
module phy_mode_ctrl_chk #(
   parameter bit CRS_EXEMPT_EN = 1'b1
) (
   input logic clk,
   input logic rst_active,
   input logic rst_s,
   input logic sw_req,
   input logic pd_any,
   input logic iso_any,
   input logic rpt_s,
   input logic analog_en,
   input logic core_rst,
   input logic mii_oe,
   input logic crs_oe
);
   logic armed;
   always_ff @(posedge clk) armed <= armed | rst_active;

   // R1: a reset may only begin after a low pin sample or a software request
   p_rst_cause_r1: assert property (@(posedge clk) disable iff (!armed)
      $rose(rst_active) |-> ($past(!rst_s) || $past(sw_req)));

   // R2: the core reset output follows any active reset
   p_core_in_rst_r2: assert property (@(posedge clk) disable iff (!armed)
      rst_active |=> core_rst);

   // R5: power-down request removes analog enable and holds the core
   p_pd_analog_r5: assert property (@(posedge clk) disable iff (!armed)
      pd_any |=> (!analog_en && core_rst));

   // R7: isolation drops the MII output enable
   p_iso_oe_r7: assert property (@(posedge clk) disable iff (!armed)
      iso_any |=> !mii_oe);

   // R8: carrier-sense enable in repeater mode, else tracks the MII group
   p_crs_rpt_r8: assert property (@(posedge clk) disable iff (!armed)
      (rpt_s && CRS_EXEMPT_EN) |=> crs_oe);
   p_crs_follow_r8: assert property (@(posedge clk) disable iff (!armed)
      !rpt_s |=> (crs_oe == mii_oe));
endmodule

bind phy_mode_ctrl phy_mode_ctrl_chk #(.CRS_EXEMPT_EN(CRS_EXEMPT_EN)) u_chk (
   .clk        (clk),
   .rst_active (rst_active),
   .rst_s      (pins_s.rst_n),
   .sw_req     (sw_req),
   .pd_any     (pd_any),
   .iso_any    (iso_any),
   .rpt_s      (pins_s.rpt),
   .analog_en  (analog_en),
   .core_rst   (core_rst),
   .mii_oe     (mii_oe),
   .crs_oe     (crs_oe)
);

// File: tb/phy_mode_ctrl_tb.sv
module phy_mode_ctrl_tb;
   localparam int MIN_CYC = 8;
   localparam int SW_CYC  = 5;
   localparam int AW      = 5;
   localparam int DW      = 16;

   logic          clk = 1'b0;
   logic          rst_pin_n = 1'b1, pd_pin = 1'b0, iso_pin = 1'b0, rpt_mode = 1'b0;
   logic          iso_strap = 1'b0, clk_strap = 1'b0;
   logic [AW-1:0] mgmt_addr = '0;
   logic          mgmt_wr = 1'b0;
   logic [DW-1:0] mgmt_wdata = '0;
   logic [DW-1:0] mgmt_rdata;
   logic          clk25_en, analog_en, core_rst, mii_oe, crs_oe;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   phy_mode_ctrl #(.RST_MIN_CYC(MIN_CYC), .SW_RST_CYC(SW_CYC), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_pin_n(rst_pin_n), .pd_pin(pd_pin), .iso_pin(iso_pin),
      .rpt_mode(rpt_mode), .iso_strap(iso_strap), .clk_strap(clk_strap),
      .mgmt_addr(mgmt_addr), .mgmt_wr(mgmt_wr), .mgmt_wdata(mgmt_wdata),
      .mgmt_rdata(mgmt_rdata), .clk25_en(clk25_en), .analog_en(analog_en),
      .core_rst(core_rst), .mii_oe(mii_oe), .crs_oe(crs_oe)
   );

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic pin_reset(input int len);
      @(negedge clk) rst_pin_n = 1'b0;
      repeat (len) @(negedge clk);
      rst_pin_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      mgmt_addr = a; mgmt_wdata = d; mgmt_wr = 1'b1;
      @(negedge clk);
      mgmt_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk) mgmt_addr = a;
      @(posedge clk);
      #1 d = mgmt_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] r;
      logic          cr;

      // reset state with isolate strap high, clock strap low
      iso_strap = 1'b1; clk_strap = 1'b0;
      pin_reset(20);
      rd(0, r);
      chk("R4 reset reg0", r, 16'h0400);
      chk("R4 clk25_en reset", {15'd0, clk25_en}, 16'd0);
      chk("R7 mii_oe after iso strap", {15'd0, mii_oe}, 16'd0);
      chk("R8 crs_oe follows without rpt", {15'd0, crs_oe}, 16'd0);
      chk("R2 core_rst released", {15'd0, core_rst}, 16'd0);
      chk("R5 analog_en idle", {15'd0, analog_en}, 16'd1);

      // R4 strap sweep
      for (int s = 0; s < 4; s++) begin
         iso_strap = s[0]; clk_strap = s[1];
         pin_reset(MIN_CYC + 4);
         rd(0, r);
         chk("R4 iso strap to bit10", r, {5'd0, s[0], 10'd0});
         chk("R4 clk strap to clk25_en", {15'd0, clk25_en}, {15'd0, s[1]});
      end

      // R1 glitch sweep: pulses up to MIN_CYC must leave bit11 alone
      iso_strap = 1'b0; clk_strap = 1'b1;
      for (int len = 1; len <= MIN_CYC + 1; len++) begin
         wr(0, 16'h0800);
         pin_reset(len);
         rd(0, r);
         chk($sformatf("R1 pulse len %0d", len), r,
             (len > MIN_CYC) ? 16'h0000 : 16'h0800);
      end

      // R3 software reset
      wr(0, 16'h0800);
      wr(0, 16'h8800);
      rd(0, r);
      cr = core_rst;
      chk("R3 bit15 during sw reset", r, 16'h8000);
      chk("R2 core_rst during sw reset", {15'd0, cr}, 16'd1);
      repeat (SW_CYC + 4) @(negedge clk);
      rd(0, r);
      chk("R3 after sw reset bit15 clear, R2 pd cleared", r, 16'h0000);
      chk("R3 core_rst released", {15'd0, core_rst}, 16'd0);
      chk("R3 clk25_en reloaded", {15'd0, clk25_en}, 16'd1);

      // R5 power-down sweep
      for (int s = 0; s < 4; s++) begin
         wr(0, {4'd0, s[1], 11'd0});
         pd_pin = s[0];
         settle();
         chk("R5 analog_en", {15'd0, analog_en}, {15'd0, ~(s[0] | s[1])});
         chk("R5 core_rst", {15'd0, core_rst}, {15'd0, s[0] | s[1]});
      end

      // R6 register access during power-down
      pd_pin = 1'b1;
      wr(0, 16'h0C00);
      rd(0, r);
      chk("R6 read in power-down", r, 16'h0C00);
      wr(0, 16'h0000);
      rd(0, r);
      chk("R6 write in power-down", r, 16'h0000);
      pd_pin = 1'b0;

      // R7 / R8 isolation sweep
      for (int s = 0; s < 8; s++) begin
         wr(0, {5'd0, s[1], 10'd0});
         iso_pin = s[0]; rpt_mode = s[2];
         settle();
         chk("R7 mii_oe", {15'd0, mii_oe}, {15'd0, ~(s[0] | s[1])});
         chk("R8 crs_oe", {15'd0, crs_oe}, {15'd0, ~(s[0] | s[1]) | s[2]});
      end
      iso_pin = 1'b0; rpt_mode = 1'b0;

      // R9 other address
      wr(0, 16'h0800);
      wr(3, 16'hFFFF);
      settle();
      rd(3, r);
      chk("R9 other address reads zero", r, 16'h0000);
      rd(0, r);
      chk("R9 reg0 unchanged", r, 16'h0800);
      chk("R9 no reset from other address", {15'd0, analog_en}, 16'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule